// File: doc/BRIEF.md
# Bus Cycle Tracker with Reset Synchronizer

This block follows the bus-state sequence of a 386-style processor clocked from a double-frequency clock. External logic can read the current bus phase directly from it. A power-good input passes through a synchronizer chain. The result is a reset output that changes only on a rising edge of that clock. The same reset also clears an internal phase bit, so the block knows which clock edge closes each processor clock.

The block tracks five bus states: idle, first address state, data state, and the pipelined first and data states. It samples the address strobe, next-address request and ready inputs only at the end of each processor clock. From the tracked state it drives a registered transceiver enable. That enable is on only while a data state is current. It switches off again as soon as a cycle ends. Gating the data transceivers with this enable, and not with the raw read strobe, keeps a peripheral that is still driving read data from fighting the processor when a write follows.

All inputs except the clock and power-good are active low. The state output is a 3-bit code.

Top module: `bus_cycle_tracker`

## Requirements
- R1: `resetOut` is 1 after `pwrGood` has been sampled low on SYNC_STAGES (default 2) consecutive rising `clk2` edges. It is 0 after `pwrGood` has been sampled high on SYNC_STAGES consecutive edges. It changes only on a rising `clk2` edge.
- R2: While `resetOut` is 1, from the next edge on, `busState` is idle (code 0) and `dataDe` is 0. `adsN` has no effect.
- R3: The first rising edge after `resetOut` falls is a mid-clock edge. State updates and input sampling happen only on every second edge after that (the 2nd, 4th, and so on). `busState` never changes on a mid-clock edge. An address strobe present only at a mid-clock edge is ignored.
- R4: State codes are idle=0, T1=1, T2=2, T1P=3, T2P=4. From idle the tracker moves to T1 when `adsN` is 0. Otherwise it stays idle, whatever `naN` is.
- R5: From T1 the tracker always moves to T2, whatever `readyN` and `naN` are.
- R6: In T2 with `readyN` = 0, the tracker moves to T1P if `adsN` is 0, otherwise to idle.
- R7: In T2 with `readyN` = 1, the tracker moves to T2P if both `naN` and `adsN` are 0. Otherwise it stays in T2, including when `adsN` is 0 without `naN`.
- R8: From T1P the tracker moves to T2P if both `naN` and `adsN` are 0, otherwise to T2.
- R9: In T2P the tracker moves to T2 when `readyN` is 0 and stays in T2P otherwise.
- R10: `dataDe` is 1 exactly while `busState` is T2 or T2P. It is therefore 0 in every idle, T1 or T1P state that follows a data state. It changes on the same edge as `busState`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2 | input | 1 | Double-frequency clock; two edges form one processor clock |
| pwrGood | input | 1 | Asynchronous power-good, high when supplies are stable |
| adsN | input | 1 | Address strobe, active low |
| naN | input | 1 | Next-address (pipeline) request, active low |
| readyN | input | 1 | Cycle termination, active low |
| resetOut | output | 1 | Synchronized reset, active high |
| busState | output | 3 | Current bus state code (see R4) |
| dataDe | output | 1 | Data transceiver enable, active high |

## Verification
A wrong tracker state appears on `busState` at the sample point after the update edge, so it is visible within one processor clock (two `clk2` edges). It also shows on `dataDe` at the same edge, because the enable is loaded from the same next-state decode. A phase error, where state moves on a mid-clock edge, appears one `clk2` edge after reset release as a state change at the wrong sample point. A synchronizer with the wrong depth moves the `resetOut` transition by whole edges, which shows up when `resetOut` is sampled after each edge following a `pwrGood` change.

// File: rtl/bus_trk_pkg.sv
package bus_trk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T1P  = 3'd3,
    ST_T2P  = 3'd4
  } busState_e;

  // Strobes from the state machine to the datapath
  typedef struct packed {
    logic deLoad;   // update edge: load transceiver enable
    logic deNext;   // value of the enable for the coming state
  } ctlStrobes_t;

endpackage

// File: rtl/bus_trk_datapath.sv
module bus_trk_datapath
  import bus_trk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk2,
  input  logic        pwrGood,
  input  ctlStrobes_t strobes,
  output logic        resetOut,
  output logic        phaseEnd,
  output logic        dataDe
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic          phase;

  // Power-good synchronizer chain, stage 0 samples the raw input
  genvar g;
  generate
    for (g = 0; g <= LAST; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk2) syncQ[g] <= pwrGood;
      end else begin : g_next
        always_ff @(posedge clk2) syncQ[g] <= syncQ[g-1];
      end
    end
  endgenerate

  assign resetOut = ~syncQ[LAST];

  // Phase bit: cleared in reset, so the first edge after release is mid-clock
  always_ff @(posedge clk2) begin
    if (resetOut) phase <= 1'b0;
    else          phase <= ~phase;
  end

  assign phaseEnd = phase & ~resetOut;

  // Registered transceiver enable, loaded with the state on update edges
  always_ff @(posedge clk2) begin
    if (resetOut)            dataDe <= 1'b0;
    else if (strobes.deLoad) dataDe <= strobes.deNext;
  end

endmodule

// File: rtl/bus_trk_control.sv
module bus_trk_control
  import bus_trk_pkg::*;
(
  input  logic        clk2,
  input  logic        resetOut,
  input  logic        phaseEnd,
  input  logic        adsN,
  input  logic        naN,
  input  logic        readyN,
  output busState_e   curState,
  output ctlStrobes_t strobes
);

  busState_e nextState;
  logic      pipeReq;

  assign pipeReq = ~naN & ~adsN;

  always_comb begin
    nextState = curState;
    unique case (curState)
      ST_IDLE: nextState = adsN ? ST_IDLE : ST_T1;
      ST_T1:   nextState = ST_T2;
      ST_T2: begin
        if (!readyN)     nextState = adsN ? ST_IDLE : ST_T1P;
        else if (pipeReq) nextState = ST_T2P;
        else             nextState = ST_T2;
      end
      ST_T1P:  nextState = pipeReq ? ST_T2P : ST_T2;
      ST_T2P:  nextState = readyN ? ST_T2P : ST_T2;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk2) begin
    if (resetOut)      curState <= ST_IDLE;
    else if (phaseEnd) curState <= nextState;
  end

  always_comb begin
    strobes.deLoad = phaseEnd;
    strobes.deNext = (nextState == ST_T2) || (nextState == ST_T2P);
  end

endmodule

// File: rtl/bus_cycle_tracker.sv
module bus_cycle_tracker
  import bus_trk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk2,
  input  logic       pwrGood,
  input  logic       adsN,
  input  logic       naN,
  input  logic       readyN,
  output logic       resetOut,
  output logic [2:0] busState,
  output logic       dataDe
);

  ctlStrobes_t strobes;
  busState_e   curState;
  logic        phaseEnd;

  bus_trk_datapath #(.SYNC_STAGES(SYNC_STAGES)) datapath_i (
    .clk2     (clk2),
    .pwrGood  (pwrGood),
    .strobes  (strobes),
    .resetOut (resetOut),
    .phaseEnd (phaseEnd),
    .dataDe   (dataDe)
  );

  bus_trk_control control_i (
    .clk2     (clk2),
    .resetOut (resetOut),
    .phaseEnd (phaseEnd),
    .adsN     (adsN),
    .naN      (naN),
    .readyN   (readyN),
    .curState (curState),
    .strobes  (strobes)
  );

  assign busState = curState;

endmodule

// File: rtl/bus_cycle_tracker_chk.sv
module bus_cycle_tracker_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic       clk2,
  input logic       pwrGood,
  input logic       adsN,
  input logic       naN,
  input logic       readyN,
  input logic       resetOut,
  input logic [2:0] busState,
  input logic       dataDe
);

  localparam int CW = $clog2(SYNC_STAGES + 1);
  localparam logic [CW-1:0] SAT = CW'(SYNC_STAGES);

  logic [CW-1:0] highCnt = '0;
  logic [CW-1:0] lowCnt  = '0;
  logic          endEdge = 1'b0;

  always_ff @(posedge clk2) begin
    if (pwrGood) begin
      lowCnt  <= '0;
      highCnt <= (highCnt == SAT) ? SAT : highCnt + 1'b1;
    end else begin
      highCnt <= '0;
      lowCnt  <= (lowCnt == SAT) ? SAT : lowCnt + 1'b1;
    end
  end

  // Independent processor-clock phase tracker
  always_ff @(posedge clk2) begin
    if (resetOut) endEdge <= 1'b0;
    else          endEdge <= ~endEdge;
  end

  // R1
  reset_assert_chk: assert property (@(posedge clk2)
    (lowCnt == SAT) |-> resetOut);

  // R1
  reset_release_chk: assert property (@(posedge clk2)
    (highCnt == SAT) |-> !resetOut);

  // R2
  reset_idle_chk: assert property (@(posedge clk2)
    resetOut |=> (busState == 3'd0 && !dataDe));

  // R3
  mid_edge_stable_chk: assert property (@(posedge clk2) disable iff (resetOut)
    !endEdge |=> $stable(busState));

  // R4
  idle_start_chk: assert property (@(posedge clk2) disable iff (resetOut)
    (endEdge && busState == 3'd0 && !adsN) |=> (busState == 3'd1));

  // R5
  t1_advance_chk: assert property (@(posedge clk2) disable iff (resetOut)
    (endEdge && busState == 3'd1) |=> (busState == 3'd2));

  // R8
  t1p_pipe_chk: assert property (@(posedge clk2) disable iff (resetOut)
    (endEdge && busState == 3'd3 && !naN && !adsN) |=> (busState == 3'd4));

  // R9
  t2p_ready_chk: assert property (@(posedge clk2) disable iff (resetOut)
    (endEdge && busState == 3'd4 && !readyN) |=> (busState == 3'd2));

  // R10
  de_state_chk: assert property (@(posedge clk2) disable iff (resetOut)
    $rose(dataDe) |-> (busState == 3'd2 || busState == 3'd4));

endmodule

bind bus_cycle_tracker bus_cycle_tracker_chk #(.SYNC_STAGES(SYNC_STAGES)) chk_i (
  .clk2     (clk2),
  .pwrGood  (pwrGood),
  .adsN     (adsN),
  .naN      (naN),
  .readyN   (readyN),
  .resetOut (resetOut),
  .busState (busState),
  .dataDe   (dataDe)
);

// File: tb/bus_cycle_tracker_tb_top.sv
`timescale 1ns/1ps
module bus_cycle_tracker_tb_top;

  logic       clk2 = 1'b0;
  logic       pwrGood = 1'b0;
  logic       adsN = 1'b1;
  logic       naN = 1'b1;
  logic       readyN = 1'b1;
  logic       resetOut;
  logic [2:0] busState;
  logic       dataDe;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;
  logic [2:0] prevSt = 3'd0;

  always #5 clk2 = ~clk2;

  bus_cycle_tracker dut_i (
    .clk2     (clk2),
    .pwrGood  (pwrGood),
    .adsN     (adsN),
    .naN      (naN),
    .readyN   (readyN),
    .resetOut (resetOut),
    .busState (busState),
    .dataDe   (dataDe)
  );

  // Rows: {adsN, naN, readyN, expected state[2:0], expected dataDe}
  localparam int NV = 21;
  localparam logic [6:0] VEC [NV] = '{
    7'b111_000_0, 7'b011_001_0, 7'b110_010_1, 7'b111_010_1,
    7'b011_010_1, 7'b110_000_0, 7'b011_001_0, 7'b101_010_1,
    7'b010_011_0, 7'b111_010_1, 7'b001_100_1, 7'b111_100_1,
    7'b110_010_1, 7'b110_000_0, 7'b101_000_0, 7'b011_001_0,
    7'b111_010_1, 7'b010_011_0, 7'b001_100_1, 7'b000_010_1,
    7'b110_000_0
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string reqFor(input logic [2:0] st, input logic rdy);
    case (st)
      3'd0:    return "R4";
      3'd1:    return "R5";
      3'd2:    return rdy ? "R7" : "R6";
      3'd3:    return "R8";
      default: return "R9";
    endcase
  endfunction

  // One processor clock: drive at negedge, mid-clock edge, update edge
  task automatic procClk(input logic a, input logic n, input logic r,
                         input logic [2:0] expSt, input logic expDe);
    string req;
    req = reqFor(prevSt, r);
    adsN = a; naN = n; readyN = r;
    @(posedge clk2); @(negedge clk2);
    chk("R3", busState, prevSt);
    @(posedge clk2); @(negedge clk2);
    chk(req, busState, expSt);
    chk("R10", dataDe, expDe);
    prevSt = busState;
  endtask

  task automatic releaseReset();
    pwrGood = 1'b1;
    @(posedge clk2); @(negedge clk2);
    chk("R1", resetOut, 1);
    @(posedge clk2); @(negedge clk2);
    chk("R1", resetOut, 0);
    prevSt = 3'd0;
  endtask

  initial begin
    // Reset state, address strobe held active must not move the tracker
    adsN = 1'b0;
    repeat (4) @(negedge clk2);
    chk("R1", resetOut, 1);
    chk("R2", busState, 0);
    chk("R2", dataDe, 0);
    adsN = 1'b1;

    releaseReset();

    // R3: strobe present only at the mid-clock edge is ignored
    adsN = 1'b0;
    @(posedge clk2); @(negedge clk2);
    chk("R3", busState, 0);
    adsN = 1'b1;
    @(posedge clk2); @(negedge clk2);
    chk("R3", busState, 0);

    for (int i = 0; i < NV; i++) begin
      procClk(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3:1], VEC[i][0]);
    end

    // Reset in the middle of a data state
    procClk(1'b0, 1'b1, 1'b1, 3'd1, 1'b0);
    procClk(1'b1, 1'b1, 1'b1, 3'd2, 1'b1);
    pwrGood = 1'b0;
    @(posedge clk2); @(negedge clk2);
    chk("R1", resetOut, 0);
    @(posedge clk2); @(negedge clk2);
    chk("R1", resetOut, 1);
    adsN = 1'b0;
    @(posedge clk2); @(negedge clk2);
    chk("R2", busState, 0);
    chk("R2", dataDe, 0);
    @(posedge clk2); @(negedge clk2);
    chk("R2", busState, 0);
    adsN = 1'b1;

    // Phase realigns after the second release
    releaseReset();
    procClk(1'b0, 1'b1, 1'b1, 3'd1, 1'b0);
    procClk(1'b1, 1'b1, 1'b0, 3'd2, 1'b1);
    procClk(1'b1, 1'b1, 1'b0, 3'd0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule